// File: doc/BRIEF.md
# Push-button abort/reset discriminator

One front-panel push button carries two jobs, and this block decides which one the operator meant from how long the button stays down. The raw contact is synchronised and debounced against a millisecond strobe. The debounced press is then timed. If the button comes back up before the long-press limit, the block raises an abort interrupt on release. If the button is still down when the limit is reached, the block issues a board reset request of fixed length. A release that follows a long press raises nothing.

Every reset that the block requests, whether from a long press or from a software write, sets a sticky reset-reason flag. That flag lives on the power-on reset only, so software can read it after the board comes back up. The abort flag shares a status register with the levels of three tick-timer interrupt sources. Any active bit in that register drives the single interrupt output. A small register port lets software read both registers, clear flags by writing 1 to them, and start a reset request.

Top module: `panel_button_ctrl`

## Requirements
- R1: After power-on reset, irq_out and rst_req are 0, RST_CTL (reg_addr 1) reads 0, and IRQ_STAT (reg_addr 0) reads 0 while timer_irq is 0.
- R2: btn_n is active low (0 = pressed). A change of its synchronised level is accepted only after it has held for DEBOUNCE_MS consecutive ms_tick strobes. A glitch shorter than that causes no event, and contact bounce before a stable level still gives exactly one event.
- R3: A debounced press released before LONG_MS strobes have elapsed sets the abort flag, IRQ_STAT bit 0, when the debounced level falls. It causes no reset request.
- R4: A debounced press that lasts LONG_MS strobes starts a reset request while the button is still held and sets the reset-reason flag, RST_CTL bit 0. Its release does not set the abort flag.
- R5: rst_req stays high from its trigger until the PULSE_MS-th ms_tick after the trigger, whatever the hold time. A further trigger while it is high is ignored.
- R6: Writing 1 to IRQ_STAT bit 0 clears the abort flag. Writing 0 to that bit leaves the flag unchanged.
- R7: IRQ_STAT bits 3..1 show the live levels of timer_irq[2:0]. Register writes have no effect on them.
- R8: irq_out is 1 exactly when some IRQ_STAT bit is 1.
- R9: Writing 1 to RST_CTL bit 1 starts a reset request and sets the reset-reason flag. RST_CTL bit 1 always reads 0.
- R10: The reset-reason flag stays set through and after the reset request. It is cleared only by writing 1 to RST_CTL bit 0 or by power-on reset. Writing 0 to that bit leaves it set. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| btn_n | input | 1 | Raw push-button contact, 0 = pressed |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| reg_addr | input | ADDR_W | Register address (0 = IRQ_STAT, 1 = RST_CTL) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| timer_irq | input | N_TMR | Tick-timer interrupt levels |
| irq_out | output | 1 | Combined interrupt |
| rst_req | output | 1 | Board reset request pulse |

## Verification
An edge on btn_n reaches the debounce filter two cycles later, through the synchroniser. The debounced level then moves on the DEBOUNCE_MS-th strobe after that, so a short press sets the abort flag, and with it irq_out, one cycle after the debounced release. The reset request rises one cycle after the LONG_MS-th strobe of a held press, or one cycle after a soft-reset write. It falls one cycle after the PULSE_MS-th following strobe, which gives exactly PULSE_MS strobe periods for a press-triggered reset. Because these instants depend on the strobe phase, a scoreboard monitor catches each rising irq_out and each completed rst_req pulse, measures the pulse width against its bounds, and pops the event the driver queued. Register values are read back only after waiting a margin of several strobes past the expected event.

// File: rtl/pb_pkg.sv
package pb_pkg;
   localparam int IRQ_STAT_OFS = 0;
   localparam int RST_CTL_OFS  = 1;
   localparam int ABORT_BIT    = 0;
   localparam int REASON_BIT   = 0;
   localparam int SOFT_BIT     = 1;
endpackage

// File: rtl/pb_debounce.sv
module pb_debounce #(
   parameter int SYNC_STAGES = 2,
   parameter int DEBOUNCE_MS = 20,
   parameter bit ACTIVE_LOW  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic btn_raw,
   output logic pressed
);
   localparam int CW = $clog2(DEBOUNCE_MS + 1);
   localparam logic IDLE_LVL = ACTIVE_LOW;

   logic [SYNC_STAGES-1:0] sy;
   logic                   raw_press;
   logic [CW-1:0]          cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= {SYNC_STAGES{IDLE_LVL}};
      else        sy <= {sy[SYNC_STAGES-2:0], btn_raw};
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign raw_press = ~sy[SYNC_STAGES-1];
      end else begin : g_high
         assign raw_press = sy[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pressed <= 1'b0;
         cnt     <= '0;
      end else if (raw_press == pressed) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt == CW'(DEBOUNCE_MS - 1)) begin
            pressed <= raw_press;
            cnt     <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R2: the filtered level only moves on a millisecond strobe
   a_r2_level_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pressed) |-> $past(tick));
endmodule

// File: rtl/pb_press_timer.sv
module pb_press_timer #(
   parameter int LONG_MS = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pressed,
   output logic abort_evt,
   output logic long_evt
);
   localparam int CW = $clog2(LONG_MS + 1);

   logic          prev;
   logic          long_seen;
   logic [CW-1:0] cnt;

   assign long_evt  = pressed & tick & ~long_seen & (cnt == CW'(LONG_MS - 1));
   assign abort_evt = prev & ~pressed & ~long_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev      <= 1'b0;
         long_seen <= 1'b0;
         cnt       <= '0;
      end else begin
         prev <= pressed;
         if (!pressed) begin
            long_seen <= 1'b0;
            cnt       <= '0;
         end else if (tick && !long_seen) begin
            if (cnt == CW'(LONG_MS - 1)) long_seen <= 1'b1;
            else                         cnt <= cnt + 1'b1;
         end
      end
   end

   // R3: an abort only ever follows the end of a debounced press
   a_r3_abort_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |-> ($past(pressed) && !pressed));
   // R4: a long press is still held in the cycle after it is recognised
   a_r4_long_while_held: assert property (@(posedge clk) disable iff (!rst_n)
      long_evt |=> !abort_evt);
endmodule

// File: rtl/pb_pulse.sv
module pb_pulse #(
   parameter int PULSE_MS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic trig,
   output logic req
);
   localparam int CW = $clog2(PULSE_MS + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
         cnt <= '0;
      end else if (!req) begin
         if (trig) begin
            req <= 1'b1;
            cnt <= '0;
         end
      end else if (tick) begin
         if (cnt == CW'(PULSE_MS - 1)) req <= 1'b0;
         else                          cnt <= cnt + 1'b1;
      end
   end

   // R5: the request only ends on a strobe
   a_r5_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> $past(tick));
endmodule

// File: rtl/panel_button_ctrl.sv
module panel_button_ctrl
   import pb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEBOUNCE_MS = 20,
   parameter int LONG_MS     = 3000,
   parameter int PULSE_MS    = 1,
   parameter int N_TMR       = 3,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_n,
   input  logic              ms_tick,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_TMR-1:0]  timer_irq,
   output logic              irq_out,
   output logic              rst_req
);
   generate
      if (SYNC_STAGES < 2 || DEBOUNCE_MS < 1 || LONG_MS <= DEBOUNCE_MS ||
          PULSE_MS < 1 || N_TMR + 1 > DATA_W || DATA_W < 2 || ADDR_W < 1) begin : g_bad_cfg
         $error("panel_button_ctrl: unsupported parameter set");
      end
   endgenerate

   logic              pressed;
   logic              abort_evt;
   logic              long_evt;
   logic              abort_flag;
   logic              reason_flag;
   logic              sel_irq;
   logic              sel_rst;
   logic              soft_wr;
   logic [N_TMR:0]    stat;
   logic              unused_wdata;

   assign sel_irq      = reg_addr == ADDR_W'(IRQ_STAT_OFS);
   assign sel_rst      = reg_addr == ADDR_W'(RST_CTL_OFS);
   assign soft_wr      = reg_wr & sel_rst & reg_wdata[SOFT_BIT];
   assign unused_wdata = ^reg_wdata;

   pb_debounce #(
      .SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_MS(DEBOUNCE_MS), .ACTIVE_LOW(1'b1)
   ) u_deb (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .btn_raw(btn_n), .pressed(pressed)
   );

   pb_press_timer #(.LONG_MS(LONG_MS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .pressed(pressed),
      .abort_evt(abort_evt), .long_evt(long_evt)
   );

   pb_pulse #(.PULSE_MS(PULSE_MS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .trig(long_evt | soft_wr),
      .req(rst_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_flag  <= 1'b0;
         reason_flag <= 1'b0;
      end else begin
         if (abort_evt)                                       abort_flag <= 1'b1;
         else if (reg_wr && sel_irq && reg_wdata[ABORT_BIT])  abort_flag <= 1'b0;
         if (long_evt || soft_wr)                             reason_flag <= 1'b1;
         else if (reg_wr && sel_rst && reg_wdata[REASON_BIT]) reason_flag <= 1'b0;
      end
   end

   generate
      for (genvar i = 0; i < N_TMR; i++) begin : g_tmr_bit
         assign stat[i+1] = timer_irq[i];
      end
   endgenerate
   assign stat[0] = abort_flag;
   assign irq_out = |stat;

   always_comb begin
      reg_rdata = '0;
      if (sel_irq)      reg_rdata[N_TMR:0]    = stat;
      else if (sel_rst) reg_rdata[REASON_BIT] = reason_flag;
   end

   // R4: a long press requests reset and records the reason
   a_r4_long_sets_reason: assert property (@(posedge clk) disable iff (!rst_n)
      long_evt |=> (rst_req && reason_flag));
   // R6: write-one clears the abort flag unless a new abort arrives
   a_r6_w1c_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel_irq && reg_wdata[ABORT_BIT] && !abort_evt) |=> !abort_flag);
   // R8: an abort event shows on the interrupt line next cycle
   a_r8_abort_irq: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |=> irq_out);
   // R9: a soft reset write records the reason
   a_r9_soft_reason: assert property (@(posedge clk) disable iff (!rst_n)
      soft_wr |=> (reason_flag && rst_req));
   // R10: the reason flag is held unless cleared by a write of one
   a_r10_reason_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (reason_flag && !(reg_wr && sel_rst && reg_wdata[REASON_BIT])) |=> reason_flag);
endmodule

// File: tb/panel_button_ctrl_bench.sv
module panel_button_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEB  = 4;
   localparam int LONG = 40;
   localparam int PUL  = 3;
   localparam int DIV  = 4;
   localparam int EV_ABORT = 1;
   localparam int EV_RESET = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       btn_n = 1'b1;
   logic       ms_tick = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [2:0] timer_irq = '0;
   logic       irq_out;
   logic       rst_req;

   int n_cmp = 0;
   int n_bad = 0;
   int exp_q[$];
   bit quiet = 1'b1;
   bit done = 1'b0;
   int tick_cnt = 0;
   int plen = 0;
   int last_len = 0;
   logic prev_irq = 1'b0;
   logic prev_rst = 1'b0;

   panel_button_ctrl #(
      .DEBOUNCE_MS(DEB), .LONG_MS(LONG), .PULSE_MS(PUL)
   ) u_panel_button_ctrl (
      .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .ms_tick(ms_tick),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .timer_irq(timer_irq), .irq_out(irq_out),
      .rst_req(rst_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      ms_tick = (tick_cnt == DIV - 1);
      tick_cnt = (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops expected events as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_out && !prev_irq && !quiet) begin
            if (exp_q.size() == 0) check("R3 unexpected abort", EV_ABORT, 0);
            else check("R3 abort event", EV_ABORT, exp_q.pop_front());
         end
         if (rst_req) plen++;
         if (!rst_req && prev_rst) begin
            last_len = plen;
            if (exp_q.size() == 0) check("R4 unexpected reset", EV_RESET, 0);
            else check("R4 reset event", EV_RESET, exp_q.pop_front());
            check("R5 pulse not longer than bound", int'(plen <= PUL*DIV), 1);
            check("R5 pulse not shorter than bound", int'(plen > (PUL-1)*DIV), 1);
            plen = 0;
         end
      end
      prev_irq = irq_out;
      prev_rst = rst_req;
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = 2'(a);
      #1 d = int'(reg_rdata);
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * DIV) @(negedge clk);
   endtask

   task automatic press(input int ticks);
      @(negedge clk);
      btn_n = 1'b0;
      wait_ticks(ticks);
      btn_n = 1'b1;
   endtask

   task automatic bounce(input int toggles);
      for (int i = 0; i < toggles; i++) begin
         repeat (3) @(negedge clk);
         btn_n = ~btn_n;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      int len_a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1 irq_out", int'(irq_out), 0);
      check("R1 rst_req", int'(rst_req), 0);
      rd(0, v); check("R1 IRQ_STAT", v, 0);
      rd(1, v); check("R1 RST_CTL", v, 0);

      // R7 / R8 timer sources
      timer_irq = 3'b101;
      rd(0, v); check("R7 timer bits", v, 8'h0A);
      check("R8 irq from timer", int'(irq_out), 1);
      wr(0, 8'hFF);
      rd(0, v); check("R7 write ignored", v, 8'h0A);
      timer_irq = 3'b000;
      rd(0, v); check("R7 timer cleared at source", v, 0);
      check("R8 irq idle", int'(irq_out), 0);
      rd(2, v); check("R10 unmapped reads 0", v, 0);
      quiet = 1'b0;

      // R3 short press
      exp_q.push_back(EV_ABORT);
      press(10);
      wait_ticks(12);
      rd(0, v); check("R3 abort flag", v, 1);
      check("R3 no reset", int'(rst_req), 0);
      rd(1, v); check("R3 no reason", v, 0);
      // R6 clear semantics
      wr(0, 0);
      rd(0, v); check("R6 write 0 keeps flag", v, 1);
      wr(0, 1);
      rd(0, v); check("R6 write 1 clears flag", v, 0);
      check("R8 irq drops", int'(irq_out), 0);

      // R2 glitch ignored
      press(2);
      wait_ticks(12);
      rd(0, v); check("R2 glitch no abort", v, 0);
      check("R2 glitch no reset", int'(rst_req), 0);

      // R2 bouncing press gives one abort
      exp_q.push_back(EV_ABORT);
      @(negedge clk); btn_n = 1'b0;
      bounce(8);
      btn_n = 1'b0;
      wait_ticks(10);
      btn_n = 1'b1;
      bounce(6);
      btn_n = 1'b1;
      wait_ticks(12);
      rd(0, v); check("R2 bounce one abort", v, 1);
      wr(0, 1);

      // R4 long press
      exp_q.push_back(EV_RESET);
      press(60);
      wait_ticks(12);
      len_a = last_len;
      check("R5 press pulse width", len_a, PUL*DIV);
      rd(0, v); check("R4 no abort after long", v, 0);
      rd(1, v); check("R4 reason set", v, 1);
      check("R10 reason after pulse", v, 1);

      // R5 width independent of hold time
      exp_q.push_back(EV_RESET);
      press(120);
      wait_ticks(12);
      check("R5 same width for longer hold", last_len, len_a);
      rd(0, v); check("R4 no abort after longer hold", v, 0);

      // R10 clear of reason
      wr(1, 0);
      rd(1, v); check("R10 write 0 keeps reason", v, 1);
      wr(1, 1);
      rd(1, v); check("R10 write 1 clears reason", v, 0);

      // R9 soft reset, retrigger ignored (R5)
      exp_q.push_back(EV_RESET);
      wr(1, 2);
      @(negedge clk);
      wr(1, 2);
      rd(1, v); check("R9 reason set, trigger bit reads 0", v, 1);
      wait_ticks(8);
      check("R9 pulse ended", int'(rst_req), 0);

      wait_ticks(4);
      check("R4 all events seen", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule